// File: doc/BRIEF.md
# Bus Width Adapter with Sub-word Ordering

This block joins a stream of 72-bit long words to an external port that may be 72, 36 or 18 bits wide. When the external side writes narrow beats, the adapter gathers two or four of them into one long word before offering it downstream. When the external side reads narrow beats, the adapter splits each accepted long word into two or four sub-words and hands them out one at a time. Both sides use a valid/ready handshake on one clock.

The width pair and the sub-word order are chosen by four configuration pins. These pins are sampled only while the active-low master reset is held, and are ignored afterwards. Only one side can be narrower than the long word at a time. A big-endian setting moves the most significant sub-word first, and a little-endian setting moves the least significant sub-word first.

Top module: `bus_width_adapter`

## Requirements
- R1: With `cfg_match` low at reset, both sides are 72 bits wide. Each accepted input word appears unchanged and in order on `out_data`, whatever the levels on `cfg_in_sel` and `cfg_out_sel`.
- R2: With `cfg_match` high at reset, `{cfg_in_sel,cfg_out_sel}` selects the sides. 11 selects a 36-bit input and a 72-bit output. 10 selects a 72-bit input and a 36-bit output. 01 selects an 18-bit input and a 72-bit output. 00 selects a 72-bit input and an 18-bit output.
- R3: With a narrow input, `out_valid` rises only after all 2 (36-bit) or 4 (18-bit) beats of a long word have been accepted.
- R4: With a narrow output, `in_ready` stays low until every sub-word of the held long word has been taken by an output handshake.
- R5: With `cfg_little` low at reset, the most significant sub-word of a long word is the first one transferred. For a narrow input, the first beat fills the top slot.
- R6: With `cfg_little` high at reset, the least significant sub-word of a long word is the first one transferred.
- R7: A narrow input takes only its low 36 or 18 bits of `in_data`, and its upper bits have no effect. A narrow output drives zero on the unused upper bits of `out_data`.
- R8: A master reset discards any partly gathered or partly issued word. In the cycle after reset ends, `out_valid` is low and `in_ready` is high, and the next beat starts a fresh long word.
- R9: Changes on the configuration pins while reset is inactive have no effect on the width pair or the sub-word order.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low master reset; configuration is sampled while it is low |
| cfg_match | input | 1 | Low: both sides full width; high: one side narrow |
| cfg_in_sel | input | 1 | Width select bit, upper bit of the pair code |
| cfg_out_sel | input | 1 | Width select bit, lower bit of the pair code |
| cfg_little | input | 1 | Low: big-endian order; high: little-endian order |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Adapter can take an input beat |
| in_data | input | WORD_W | Input beat; only the low bits are used when the input is narrow |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_data | output | WORD_W | Output beat, zero-extended when the output is narrow |

## Verification
The hardest case to reach from the ports is a master reset that lands partway through a long word, because the bench has to stop feeding beats at a chosen count. A directed sequence sends two of four narrow beats, resets with the same configuration, and then expects a clean new word made only of the following four beats. Randomized streams with random stalls on both sides cover every width pair in both orders. During these streams the bench keeps changing the configuration pins and puts random values in the unused upper input bits, so the effect of R7 and R9 shows up in the compared data.

// File: rtl/bus_width_adapter.sv
module bus_width_adapter #(
  parameter int WORD_W = 72
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_match,
  input  logic              cfg_in_sel,
  input  logic              cfg_out_sel,
  input  logic              cfg_little,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  localparam int HALF = WORD_W / 2;
  localparam int QTR  = WORD_W / 4;

  typedef enum logic [2:0] {M_PASS, M_IN_HALF, M_OUT_HALF, M_IN_QTR, M_OUT_QTR} mode_t;

  mode_t             mode_q, mode_d;
  logic              little_q;
  logic [WORD_W-1:0] buf_q;
  logic              full_q;
  logic [1:0]        cnt_q, last_cnt, slot;
  logic              pack, unpack, in_fire, out_fire;

  always_comb begin
    if (!cfg_match) mode_d = M_PASS;
    else begin
      case ({cfg_in_sel, cfg_out_sel})
        2'b11:   mode_d = M_IN_HALF;
        2'b10:   mode_d = M_OUT_HALF;
        2'b01:   mode_d = M_IN_QTR;
        default: mode_d = M_OUT_QTR;
      endcase
    end
  end

  assign pack     = (mode_q == M_IN_HALF) || (mode_q == M_IN_QTR);
  assign unpack   = (mode_q == M_OUT_HALF) || (mode_q == M_OUT_QTR);
  assign last_cnt = ((mode_q == M_IN_QTR) || (mode_q == M_OUT_QTR)) ? 2'd3 :
                    (mode_q == M_PASS) ? 2'd0 : 2'd1;
  assign slot     = little_q ? cnt_q : last_cnt - cnt_q;

  assign in_ready  = rst_n && !full_q;
  assign out_valid = full_q;
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= mode_d;
      little_q <= cfg_little;
      full_q   <= 1'b0;
      cnt_q    <= 2'd0;
      buf_q    <= '0;
    end else begin
      if (in_fire) begin
        case (mode_q)
          M_IN_HALF: buf_q[int'(slot)*HALF +: HALF] <= in_data[HALF-1:0];
          M_IN_QTR:  buf_q[int'(slot)*QTR +: QTR]   <= in_data[QTR-1:0];
          default:   buf_q <= in_data;
        endcase
      end
      if (pack) begin
        if (in_fire) begin
          if (cnt_q == last_cnt) begin
            full_q <= 1'b1;
            cnt_q  <= 2'd0;
          end else cnt_q <= cnt_q + 2'd1;
        end
        if (out_fire) full_q <= 1'b0;
      end else if (unpack) begin
        if (in_fire) full_q <= 1'b1;
        if (out_fire) begin
          if (cnt_q == last_cnt) begin
            full_q <= 1'b0;
            cnt_q  <= 2'd0;
          end else cnt_q <= cnt_q + 2'd1;
        end
      end else begin
        if (in_fire) full_q <= 1'b1;
        if (out_fire) full_q <= 1'b0;
      end
    end
  end

  always_comb begin
    out_data = buf_q;
    case (mode_q)
      M_OUT_HALF: begin
        out_data = '0;
        out_data[HALF-1:0] = buf_q[int'(slot)*HALF +: HALF];
      end
      M_OUT_QTR: begin
        out_data = '0;
        out_data[QTR-1:0] = buf_q[int'(slot)*QTR +: QTR];
      end
      default: ;
    endcase
  end

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q) && $stable(little_q));

  // R8
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid && in_ready && cnt_q == 2'd0);

  // R1
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == M_PASS && in_fire |=> out_valid && out_data == $past(in_data));

  // R4
  unpack_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unpack && out_fire && cnt_q != last_cnt |=> !in_ready);
endmodule

// File: tb/test_bus_width_adapter.sv
module test_bus_width_adapter;
  localparam int W = 72;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_match = 1'b0, cfg_in_sel = 1'b0, cfg_out_sel = 1'b0, cfg_little = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid;
  logic [W-1:0] in_data = '0;
  logic [W-1:0] out_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bus_width_adapter #(.WORD_W(W)) i_bus_width_adapter (
    .clk(clk), .rst_n(rst_n), .cfg_match(cfg_match), .cfg_in_sel(cfg_in_sel),
    .cfg_out_sel(cfg_out_sel), .cfg_little(cfg_little), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rnd72();
    return {$urandom(), $urandom(), $urandom()};
  endfunction

  function automatic logic [W-1:0] sub(logic [W-1:0] w, int k, int idx, bit little);
    int slot = little ? idx : k - 1 - idx;
    int width = W / k;
    logic [W-1:0] mask = {W{1'b1}} >> (W - width);
    return (w >> (slot * width)) & mask;
  endfunction

  task automatic do_reset(bit m, bit i, bit o, bit l);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    cfg_match = m; cfg_in_sel = i; cfg_out_sel = o; cfg_little = l;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!out_valid, "R8 out_valid after reset", W'(out_valid), W'(0));
    chk(in_ready, "R8 in_ready after reset", W'(in_ready), W'(1));
  endtask

  task automatic run_stream(bit m, bit i, bit o, bit l, int nw);
    int kin = 1, kout = 1, in_done = 0, out_done = 0, cyc = 0;
    bit prev_hold = 0;
    logic [W-1:0] prev_data = '0;
    logic [W-1:0] words [16];
    string tag;
    if (m) begin
      case ({i, o})
        2'b11: kin = 2;
        2'b10: kout = 2;
        2'b01: kin = 4;
        default: kout = 4;
      endcase
    end
    tag = $sformatf("%s %s", m ? "R2 R7" : "R1", l ? "R6" : "R5");
    for (int n = 0; n < 16; n++) words[n] = rnd72();
    do_reset(m, i, o, l);
    while (out_done < nw * kout && cyc < 3000) begin
      if (prev_hold) chk(out_valid && out_data == prev_data, "R10 hold", out_data, prev_data);
      if (out_valid) chk(in_done / kin >= out_done / kout + 1, "R3 early out_valid",
                         W'(in_done), W'((out_done / kout + 1) * kin));
      if (in_ready) chk(out_done / kout >= in_done / kin, "R4 early in_ready",
                        W'(out_done), W'((in_done / kin) * kout));
      cfg_match = $urandom(); cfg_in_sel = $urandom();
      cfg_out_sel = $urandom(); cfg_little = $urandom();
      in_valid = (in_done < nw * kin) && ($urandom() % 4 != 0);
      if (in_done < nw * kin) begin
        in_data = sub(words[in_done / kin], kin, in_done % kin, l);
        if (kin > 1) in_data = in_data | (rnd72() << (W / kin));
      end else in_data = rnd72();
      out_ready = ($urandom() % 3 != 0);
      #1;
      if (out_valid && out_ready) begin
        chk(out_data == sub(words[out_done / kout], kout, out_done % kout, l),
            $sformatf("%s R9 data", tag), out_data,
            sub(words[out_done / kout], kout, out_done % kout, l));
        out_done++;
      end
      prev_hold = out_valid && !out_ready;
      prev_data = out_data;
      if (in_valid && in_ready) in_done++;
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 3000) chk(1'b0, "R10 stream stalled", W'(out_done), W'(nw * kout));
    in_valid = 1'b0; out_ready = 1'b0;
  endtask

  task automatic push(logic [W-1:0] d);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    logic [W-1:0] wa, wb;
    void'($urandom(32'd20250607));
    repeat (2) @(negedge clk);

    for (int l = 0; l < 2; l++) begin
      run_stream(1'b0, 1'b0, 1'b0, l[0], 12);
      run_stream(1'b0, 1'b1, 1'b0, l[0], 12);
      run_stream(1'b1, 1'b1, 1'b1, l[0], 12);
      run_stream(1'b1, 1'b1, 1'b0, l[0], 12);
      run_stream(1'b1, 1'b0, 1'b1, l[0], 12);
      run_stream(1'b1, 1'b0, 1'b0, l[0], 12);
    end

    // R8: reset in the middle of gathering an 18-bit input, big-endian
    wa = rnd72(); wb = rnd72();
    do_reset(1'b1, 1'b0, 1'b1, 1'b0);
    push(sub(wa, 4, 0, 0));
    push(sub(wa, 4, 1, 0));
    do_reset(1'b1, 1'b0, 1'b1, 1'b0);
    for (int b = 0; b < 3; b++) push(sub(wb, 4, b, 0));
    chk(!out_valid, "R3 three of four beats", W'(out_valid), W'(0));
    push(sub(wb, 4, 3, 0));
    chk(out_valid && out_data == wb, "R8 fresh word after reset", out_data, wb);

    // R4 and R6: 18-bit output, little-endian, consumer stalled
    do_reset(1'b1, 1'b0, 1'b0, 1'b1);
    push(wa);
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(!in_ready, "R4 in_ready while word held", W'(in_ready), W'(0));
    chk(out_data == W'(wa[17:0]), "R6 first sub-word", out_data, W'(wa[17:0]));
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(!in_ready && out_data == W'(wa[71:54]), "R6 last sub-word", out_data, W'(wa[71:54]));
    @(negedge clk);
    out_ready = 1'b0;
    chk(in_ready && !out_valid, "R4 in_ready after last sub-word", W'(in_ready), W'(1));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R10 watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule